// File: doc/BRIEF.md
# Event Timer Global Register Front End

This block is the register front end of an event timer. It owns a 64-bit main up-counter, the global configuration (enable and legacy route), a per-timer interrupt status register and a read-only capability word pair. It also decodes the 1 KB register window. The global registers sit in the first 256 bytes. The space from 0x100 to 0x3FF is split into 32-byte slots, and each slot is handed to one timer channel through a one-hot select, a 5-bit offset and read/write strobes. Slots beyond the implemented timer count read as zero and swallow writes. Only aligned 4-byte accesses are honoured.

The bus side is run by a two-state machine. `BUS_IDLE` accepts a request when `req_valid` is high (transition *accept*). `BUS_RESP` presents `resp_valid` with the registered read data for one cycle, then returns to `BUS_IDLE` (transition *retire*). The counter is run by a second machine. It is in `CNT_HALTED` while the global enable is clear and in `CNT_RUNNING` while it is set. The `CNT_HALTED`→`CNT_RUNNING` transition (*resume*) fires a one-cycle re-arm pulse to every channel whose comparator is not all ones. The `CNT_RUNNING`→`CNT_HALTED` transition (*freeze*) stops the counter at its current value.

The timer count parameter is clamped to the range 3..24, since 24 slots fit the window.

Top module: `evt_timer_regfront`

## Requirements
- R1: After reset, the main counter, the config register and the status register are 0. `resp_valid`, `chan_rearm`, `glb_enable` and `glb_legacy` are low.
- R2: Offset 0x000 reads 0x8086A001 with (timer count − 1) ORed into bits 12:8. Offset 0x004 reads the tick period in femtoseconds (parameter TICK_FS). Writes to both offsets are ignored.
- R3: Offset 0x010 is the config register: bit 0 is enable and bit 1 is legacy route. All other bits read 0. Offset 0x014 reads 0 and ignores writes.
- R4: While enable is set, the counter rises by exactly one per clock, starting on the second edge after the enabling write is accepted. While enable is clear, the counter holds its value.
- R5: Offsets 0x0F0 and 0x0F4 read and write the low and high counter halves independently. A counter write while enabled takes effect and pulses `count_wr_warn` for one cycle; a write while halted does not pulse it.
- R6: In the cycle after the enabling write is accepted, `chan_rearm[n]` pulses for one cycle for each timer n whose `chan_cmp_ones[n]` is low.
- R7: Offset 0x020 is the status register, bit n for timer n. A `chan_event[n]` pulse sets bit n while enabled. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. While disabled, all bits are 0 and events are ignored.
- R8: An access at 0x100 + n·0x20 + k (n < timer count) raises `chan_sel` one-hot on bit n, with `chan_offset` = k and `chan_rd` or `chan_wr`. The response data is channel n's `chan_rdata` word.
- R9: An access to a slot with index ≥ timer count raises no channel strobe, and a read of it returns 0.
- R10: An access with size other than 4 or with address bits 1:0 non-zero changes no state, raises no strobe, and reads 0.
- R11: `req_ready` is high in `BUS_IDLE`. Every accepted request gets exactly one `resp_valid` cycle, on the cycle after acceptance.
- R12: A timer count parameter below 3 is raised to 3: the capability count field reads 2, and slot 2 is a live channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Front end can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address in the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 32 | Read data (0 for writes) |
| chan_sel | output | NT | One-hot channel select |
| chan_offset | output | 5 | Byte offset within the channel slot |
| chan_wr | output | 1 | Channel write strobe |
| chan_rd | output | 1 | Channel read strobe |
| chan_wdata | output | 32 | Channel write data |
| chan_rdata | input | NT·32 | Read words of all channels, channel n at bits 32n+31:32n |
| chan_cmp_ones | input | NT | Channel comparator is all ones |
| chan_rearm | output | NT | One-cycle re-arm pulse on resume |
| chan_event | input | NT | Channel interrupt event pulses |
| main_count | output | 64 | Main counter value |
| glb_enable | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy route bit |
| count_wr_warn | output | 1 | Counter written while running |

## Verification
The inline properties watch, on every cycle, the per-cycle counter step and hold, the one-hot channel select, the silence of absent and malformed accesses, the single-cycle response, the status wipe while disabled, and the capability read value. Only the bench scenarios can show the cross-register effects. These are: the exact counter value seen by a read a known number of cycles after resume; the carry across the halves after a split write; write-1-to-clear on a status bit while events set others; and the re-arm vector taken from comparator flags. A seeded random sweep checks the whole window against a bench model with the counter frozen.

// File: rtl/evt_front_pkg.sv
package evt_front_pkg;

    localparam int unsigned MIN_TIMERS = 3;
    localparam int unsigned MAX_TIMERS = 24;
    localparam int unsigned SLOT_W     = 5;
    localparam logic [31:0] CAP_BASE   = 32'h8086_A001;

    localparam logic [7:0] OFS_CAP    = 8'h00;
    localparam logic [7:0] OFS_PERIOD = 8'h04;
    localparam logic [7:0] OFS_CFG    = 8'h10;
    localparam logic [7:0] OFS_CFG_HI = 8'h14;
    localparam logic [7:0] OFS_STATUS = 8'h20;
    localparam logic [7:0] OFS_CNT_LO = 8'hF0;
    localparam logic [7:0] OFS_CNT_HI = 8'hF4;

    typedef enum logic [0:0] {BUS_IDLE, BUS_RESP} bus_state_e;
    typedef enum logic [0:0] {CNT_HALTED, CNT_RUNNING} cnt_state_e;
    typedef enum logic [2:0] {
        REG_NONE, REG_CAP, REG_PERIOD, REG_CFG,
        REG_STATUS, REG_CNT_LO, REG_CNT_HI, REG_CHAN
    } reg_sel_e;

    function automatic int unsigned clamp_timers(input int unsigned n);
        if (n < MIN_TIMERS) return MIN_TIMERS;
        if (n > MAX_TIMERS) return MAX_TIMERS;
        return n;
    endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_front_pkg::*;
#(
    parameter int unsigned NT = 3
) (
    input  logic [9:0]        addr,
    input  logic [2:0]        size,
    output reg_sel_e          sel,
    output logic [SLOT_W-1:0] slot
);
    logic legal;

    always_comb begin
        legal = (size == 3'd4) && (addr[1:0] == 2'b00);
        slot  = addr[9:5] - 5'd8;
        sel   = REG_NONE;
        if (legal) begin
            if (addr[9:8] != 2'b00) begin
                if (slot < SLOT_W'(NT)) sel = REG_CHAN;
            end else begin
                unique case (addr[7:0])
                    OFS_CAP:    sel = REG_CAP;
                    OFS_PERIOD: sel = REG_PERIOD;
                    OFS_CFG:    sel = REG_CFG;
                    OFS_STATUS: sel = REG_STATUS;
                    OFS_CNT_LO: sel = REG_CNT_LO;
                    OFS_CNT_HI: sel = REG_CNT_HI;
                    default:    sel = REG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_front_pkg::*;
#(
    parameter int unsigned CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] cnt,
    output logic          resume,
    output logic          wr_warn
);
    localparam int unsigned HW = CW / 2;

    cnt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_HALTED;
        else        state_q <= state_d;
    end

    // transitions: resume (HALTED->RUNNING), freeze (RUNNING->HALTED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALTED:  if (en)  state_d = CNT_RUNNING;
            CNT_RUNNING: if (!en) state_d = CNT_HALTED;
            default:     state_d = CNT_HALTED;
        endcase
    end

    // outputs
    assign resume = (state_q == CNT_HALTED) && en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            wr_warn <= 1'b0;
        end else begin
            wr_warn <= (wr_lo || wr_hi) && en;
            if (wr_lo)      cnt <= {cnt[CW-1:HW], wdata[HW-1:0]};
            else if (wr_hi) cnt <= {wdata[HW-1:0], cnt[HW-1:0]};
            else if (en)    cnt <= cnt + 1'b1;
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_lo && !wr_hi) |=> $stable(cnt));

    p_warn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !wr_warn);

endmodule

// File: rtl/evt_int_status.sv
module evt_int_status #(
    parameter int unsigned NT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NT-1:0] evt,
    input  logic          clr_we,
    input  logic [NT-1:0] clr_mask,
    output logic [NT-1:0] status
);
    logic [NT-1:0] keep;

    assign keep = clr_we ? ~clr_mask : '1;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) status <= '0;
        else               status <= (status & keep) | evt;
    end

    p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (status == '0));

    p_evt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (evt != '0)) |=> ((status & $past(evt)) == $past(evt)));

endmodule

// File: rtl/evt_timer_regfront.sv
module evt_timer_regfront
    import evt_front_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3,
    parameter logic [31:0] TICK_FS    = 32'd20_000_000
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    output logic                                        req_ready,
    input  logic                                        req_write,
    input  logic [9:0]                                  req_addr,
    input  logic [2:0]                                  req_size,
    input  logic [31:0]                                 req_wdata,
    output logic                                        resp_valid,
    output logic [31:0]                                 resp_rdata,
    output logic [clamp_timers(NUM_TIMERS)-1:0]         chan_sel,
    output logic [4:0]                                  chan_offset,
    output logic                                        chan_wr,
    output logic                                        chan_rd,
    output logic [31:0]                                 chan_wdata,
    input  logic [clamp_timers(NUM_TIMERS)*32-1:0]      chan_rdata,
    input  logic [clamp_timers(NUM_TIMERS)-1:0]         chan_cmp_ones,
    output logic [clamp_timers(NUM_TIMERS)-1:0]         chan_rearm,
    input  logic [clamp_timers(NUM_TIMERS)-1:0]         chan_event,
    output logic [63:0]                                 main_count,
    output logic                                        glb_enable,
    output logic                                        glb_legacy,
    output logic                                        count_wr_warn
);
    localparam int unsigned NT      = clamp_timers(NUM_TIMERS);
    localparam logic [31:0] CAP_LOW = CAP_BASE | (32'(NT - 1) << 8);

    bus_state_e        state_q, state_d;
    reg_sel_e          dec_sel;
    logic [SLOT_W-1:0] dec_slot;
    logic              accept;
    logic [1:0]        cfg_q;
    logic [NT-1:0]     status;
    logic              resume;
    logic [31:0]       rd_mux;
    logic              wr_cfg, wr_lo, wr_hi, wr_stat;

    evt_addr_decode #(.NT(NT)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .sel  (dec_sel),
        .slot (dec_slot)
    );

    // bus state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept (IDLE->RESP), retire (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // bus outputs
    assign req_ready  = (state_q == BUS_IDLE);
    assign resp_valid = (state_q == BUS_RESP);
    assign accept     = req_valid && req_ready;

    assign wr_cfg  = accept && req_write && (dec_sel == REG_CFG);
    assign wr_lo   = accept && req_write && (dec_sel == REG_CNT_LO);
    assign wr_hi   = accept && req_write && (dec_sel == REG_CNT_HI);
    assign wr_stat = accept && req_write && (dec_sel == REG_STATUS);

    // channel hand-off
    generate
        for (genvar n = 0; n < NT; n++) begin : g_sel
            assign chan_sel[n] = accept && (dec_sel == REG_CHAN) &&
                                 (dec_slot == SLOT_W'(n));
        end
    endgenerate

    assign chan_offset = req_addr[4:0];
    assign chan_wdata  = req_wdata;
    assign chan_wr     = accept && req_write  && (dec_sel == REG_CHAN);
    assign chan_rd     = accept && !req_write && (dec_sel == REG_CHAN);

    // global config
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= 2'b00;
        else if (wr_cfg) cfg_q <= req_wdata[1:0];
    end

    assign glb_enable = cfg_q[0];
    assign glb_legacy = cfg_q[1];

    evt_main_counter #(.CW(64)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_q[0]),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (req_wdata),
        .cnt     (main_count),
        .resume  (resume),
        .wr_warn (count_wr_warn)
    );

    assign chan_rearm = {NT{resume}} & ~chan_cmp_ones;

    evt_int_status #(.NT(NT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_q[0]),
        .evt      (chan_event),
        .clr_we   (wr_stat),
        .clr_mask (req_wdata[NT-1:0]),
        .status   (status)
    );

    // read data mux
    always_comb begin
        rd_mux = '0;
        unique case (dec_sel)
            REG_CAP:    rd_mux = CAP_LOW;
            REG_PERIOD: rd_mux = TICK_FS;
            REG_CFG:    rd_mux = {30'd0, cfg_q};
            REG_STATUS: rd_mux = 32'(status);
            REG_CNT_LO: rd_mux = main_count[31:0];
            REG_CNT_HI: rd_mux = main_count[63:32];
            REG_CHAN:   rd_mux = chan_rdata[dec_slot*32 +: 32];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      resp_rdata <= '0;
        else if (accept) resp_rdata <= req_write ? 32'd0 : rd_mux;
    end

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));

    p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr[9:8] != 2'b00) &&
         ((req_addr[9:5] - 5'd8) >= SLOT_W'(NT)))
        |-> ((chan_sel == '0) && !chan_wr && !chan_rd));

    p_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_size != 3'd4)) |-> ((chan_sel == '0) && !chan_wr && !chan_rd));

    p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid);

    p_resp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_cap_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && (req_addr == 10'h000) && (req_size == 3'd4))
        |=> (resp_rdata == CAP_LOW));

    p_rearm_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rearm != '0) |-> $rose(glb_enable));

endmodule

// File: tb/sim_evt_timer_regfront.sv
module sim_evt_timer_regfront;

    localparam int NT = 3;   // NUM_TIMERS=2 clamps to 3

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]        req_addr = '0;
    logic [2:0]        req_size = 3'd4;
    logic [31:0]       req_wdata = '0;
    logic              req_ready, resp_valid;
    logic [31:0]       resp_rdata;
    logic [NT-1:0]     chan_sel, chan_rearm;
    logic [NT-1:0]     chan_cmp_ones = '1;
    logic [NT-1:0]     chan_event = '0;
    logic [4:0]        chan_offset;
    logic              chan_wr, chan_rd, count_wr_warn, glb_enable, glb_legacy;
    logic [31:0]       chan_wdata;
    logic [NT*32-1:0]  chan_rdata;
    logic [63:0]       main_count;

    int unsigned checks = 0, failures = 0, cyc = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] chan_pat(input int n, input logic [4:0] off);
        return {16'hC0DE, 8'(n), 3'b000, off};
    endfunction

    always_comb begin
        for (int n = 0; n < NT; n++) chan_rdata[n*32 +: 32] = chan_pat(n, chan_offset);
    end

    evt_timer_regfront #(.NUM_TIMERS(2), .TICK_FS(32'd20_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .chan_sel(chan_sel), .chan_offset(chan_offset), .chan_wr(chan_wr),
        .chan_rd(chan_rd), .chan_wdata(chan_wdata), .chan_rdata(chan_rdata),
        .chan_cmp_ones(chan_cmp_ones), .chan_rearm(chan_rearm),
        .chan_event(chan_event), .main_count(main_count),
        .glb_enable(glb_enable), .glb_legacy(glb_legacy),
        .count_wr_warn(count_wr_warn)
    );

    // snapshots taken during each access
    logic [NT-1:0] s_sel, s_rearm;
    logic          s_wr, s_rd, s_warn, s_rvalid, s_ready;
    logic [4:0]    s_off;
    int unsigned   s_cyc;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [9:0] a, input logic [2:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        #1;
        s_ready = req_ready; s_sel = chan_sel; s_wr = chan_wr; s_rd = chan_rd;
        s_off = chan_offset;
        @(negedge clk);
        s_cyc = cyc; s_rvalid = resp_valid; s_warn = count_wr_warn; s_rearm = chan_rearm;
        rd = resp_rdata;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [9:0] a, input logic [1:0] cfg,
                                               input logic [63:0] cnt);
        int slot;
        if (a[9:8] != 2'b00) begin
            slot = int'(a[9:5]) - 8;
            return (slot < NT) ? chan_pat(slot, a[4:0]) : 32'd0;
        end
        case (a[7:0])
            8'h00:   return 32'h8086_A201;
            8'h04:   return 32'd20_000_000;
            8'h10:   return {30'd0, cfg};
            8'hF0:   return cnt[31:0];
            8'hF4:   return cnt[63:32];
            default: return 32'd0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd, rd2;
        logic [63:0] v, m0;
        logic [1:0]  cfg_m;
        logic [63:0] cnt_m;
        int unsigned c0, c1;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk(main_count == 0 && !glb_enable && !glb_legacy && !resp_valid &&
            chan_rearm == 0 && req_ready, "R1 reset outputs", main_count, 0);
        bus(0, 10'h010, 3'd4, 0, rd); chk(rd == 0, "R1 cfg", rd, 0);
        bus(0, 10'h020, 3'd4, 0, rd); chk(rd == 0, "R1 status", rd, 0);
        bus(0, 10'h0F0, 3'd4, 0, rd); chk(rd == 0, "R1 count lo", rd, 0);
        chk(s_rvalid, "R11 resp one cycle after accept", s_rvalid, 1);
        @(negedge clk); chk(!resp_valid && req_ready, "R11 single resp", resp_valid, 0);

        // R2 / R12 capability
        bus(0, 10'h000, 3'd4, 0, rd); chk(rd == 32'h8086_A201, "R2 R12 cap low", rd, 32'h8086_A201);
        bus(0, 10'h004, 3'd4, 0, rd); chk(rd == 32'd20_000_000, "R2 period", rd, 20_000_000);
        bus(1, 10'h000, 3'd4, 32'hFFFF_FFFF, rd);
        bus(1, 10'h004, 3'd4, 32'h1, rd);
        bus(0, 10'h000, 3'd4, 0, rd); chk(rd == 32'h8086_A201, "R2 cap write ignored", rd, 32'h8086_A201);
        bus(0, 10'h004, 3'd4, 0, rd); chk(rd == 32'd20_000_000, "R2 period write ignored", rd, 20_000_000);

        // R3 config
        bus(1, 10'h010, 3'd4, 32'hFFFF_FFFE, rd);
        bus(0, 10'h010, 3'd4, 0, rd); chk(rd == 32'h2, "R3 cfg legacy only", rd, 2);
        chk(glb_legacy && !glb_enable, "R3 legacy pin", {glb_legacy, glb_enable}, 2'b10);
        bus(1, 10'h014, 3'd4, 32'hFFFF_FFFF, rd);
        bus(0, 10'h014, 3'd4, 0, rd); chk(rd == 0, "R3 cfg high reads 0", rd, 0);
        bus(0, 10'h010, 3'd4, 0, rd); chk(rd == 32'h2, "R3 cfg high write ignored", rd, 2);

        // R4 hold while disabled
        v = main_count; repeat (7) @(negedge clk);
        chk(main_count == v, "R4 hold halted", main_count, v);

        // R5 halted split writes
        bus(1, 10'h0F0, 3'd4, 32'hFFFF_FFFE, rd);
        chk(!s_warn, "R5 no warn halted", s_warn, 0);
        bus(1, 10'h0F4, 3'd4, 32'h0000_0001, rd);
        bus(0, 10'h0F0, 3'd4, 0, rd); chk(rd == 32'hFFFF_FFFE, "R5 lo half", rd, 32'hFFFF_FFFE);
        bus(0, 10'h0F4, 3'd4, 0, rd); chk(rd == 32'h1, "R5 hi half", rd, 1);

        // R6 resume re-arm
        chan_cmp_ones = 3'b010;
        bus(1, 10'h010, 3'd4, 32'h1, rd); c0 = s_cyc;
        chk(s_rearm == 3'b101, "R6 rearm vector", s_rearm, 3'b101);
        @(negedge clk); chk(chan_rearm == 0, "R6 rearm one cycle", chan_rearm, 0);

        // R4 counting with carry across halves
        v = 64'h1_FFFF_FFFE;
        bus(0, 10'h0F0, 3'd4, 0, rd); c1 = s_cyc;
        m0 = v + 64'(c1 - c0 - 1);
        chk(rd == m0[31:0], "R4 count lo after resume", rd, m0[31:0]);
        bus(0, 10'h0F4, 3'd4, 0, rd); c1 = s_cyc;
        m0 = v + 64'(c1 - c0 - 1);
        chk(rd == m0[63:32], "R4 carry into hi", rd, m0[63:32]);
        v = main_count; repeat (5) @(negedge clk);
        chk(main_count == v + 5, "R4 step per clock", main_count, v + 5);

        // R5 running write
        bus(1, 10'h0F0, 3'd4, 32'h10, rd); c0 = s_cyc;
        chk(s_warn, "R5 warn running", s_warn, 1);
        bus(0, 10'h0F0, 3'd4, 0, rd); c1 = s_cyc;
        chk(rd == 32'h10 + (c1 - c0 - 1), "R5 running write", rd, 32'h10 + (c1 - c0 - 1));

        // R7 status
        @(negedge clk); chan_event = 3'b101;
        @(negedge clk); chan_event = 3'b000;
        bus(0, 10'h020, 3'd4, 0, rd); chk(rd == 32'h5, "R7 events set", rd, 5);
        bus(1, 10'h020, 3'd4, 32'h1, rd);
        bus(0, 10'h020, 3'd4, 0, rd); chk(rd == 32'h4, "R7 w1c", rd, 4);
        bus(1, 10'h020, 3'd4, 32'h0, rd);
        bus(0, 10'h020, 3'd4, 0, rd); chk(rd == 32'h4, "R7 write 0 no effect", rd, 4);
        bus(1, 10'h010, 3'd4, 32'h0, rd);
        bus(0, 10'h020, 3'd4, 0, rd); chk(rd == 0, "R7 disable clears", rd, 0);
        @(negedge clk); chan_event = 3'b111;
        @(negedge clk); chan_event = 3'b000;
        bus(0, 10'h020, 3'd4, 0, rd); chk(rd == 0, "R7 events ignored off", rd, 0);

        // R4 freeze
        bus(0, 10'h0F0, 3'd4, 0, rd);
        repeat (4) @(negedge clk);
        bus(0, 10'h0F0, 3'd4, 0, rd2); chk(rd2 == rd, "R4 frozen", rd2, rd);

        // R8 channels
        for (int n = 0; n < NT; n++) begin
            bus(0, 10'(10'h100 + n*32 + 8), 3'd4, 0, rd);
            chk(s_sel == 3'(1 << n) && s_rd && !s_wr && s_off == 5'd8, "R8 read strobe",
                s_sel, 3'(1 << n));
            chk(rd == chan_pat(n, 5'd8), "R8 read data", rd, chan_pat(n, 5'd8));
            bus(1, 10'(10'h100 + n*32 + 4), 3'd4, 32'hA5A5_0000, rd);
            chk(s_sel == 3'(1 << n) && s_wr && !s_rd, "R8 write strobe", s_sel, 3'(1 << n));
        end
        chk(chan_sel == 0, "R12 idle no strobe", chan_sel, 0);

        // R9 absent timers
        bus(0, 10'h160, 3'd4, 0, rd); chk(rd == 0 && s_sel == 0 && !s_rd, "R9 slot 3", rd, 0);
        bus(1, 10'h3FC, 3'd4, 32'hFFFF_FFFF, rd); chk(s_sel == 0 && !s_wr, "R9 top write", s_sel, 0);

        // R10 bad size / alignment
        bus(1, 10'h010, 3'd2, 32'h3, rd);
        bus(0, 10'h010, 3'd4, 0, rd); chk(rd == 32'h0, "R10 size 2 write ignored", rd, 0);
        bus(0, 10'h102, 3'd4, 0, rd); chk(rd == 0 && s_sel == 0, "R10 misaligned", rd, 0);
        bus(0, 10'h000, 3'd1, 0, rd); chk(rd == 0, "R10 byte read", rd, 0);

        // random sweep, counter halted
        bus(0, 10'h0F0, 3'd4, 0, rd); cnt_m[31:0] = rd;
        bus(0, 10'h0F4, 3'd4, 0, rd); cnt_m[63:32] = rd;
        cfg_m = 2'b00;
        for (int i = 0; i < 300; i++) begin
            logic [9:0]  a;
            logic [31:0] wd;
            a  = 10'($urandom_range(0, 255) << 2);
            wd = $urandom;
            if ($urandom_range(0, 3) == 0) begin
                if (a == 10'h010) wd[0] = 1'b0;
                bus(1, a, 3'd4, wd, rd);
                if (a == 10'h010) cfg_m = wd[1:0];
                if (a == 10'h0F0) cnt_m[31:0] = wd;
                if (a == 10'h0F4) cnt_m[63:32] = wd;
            end else begin
                bus(0, a, 3'd4, 0, rd);
                chk(rd == model_read(a, cfg_m, cnt_m) && s_ready,
                    "R8 R9 R2 random read", rd, model_read(a, cfg_m, cnt_m));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule